// File: doc/BRIEF.md
# Immediate-Operand ALU Instruction Executor

This block executes a small family of 32-bit integer instructions that carry a four-byte immediate. It takes instruction bytes one at a time over a valid/ready handshake. It decodes the opcode and, for the grouped form, the addressing byte that follows. It then combines the immediate with a destination using add, subtract, AND, OR or XOR, and writes the result back. Results wrap modulo 2^32, and no flags are produced.

The destination is either one of eight 32-bit registers or a 32-bit little-endian word in a byte-addressed local memory. For a memory destination, the address is held in a register. A register result is written back one cycle after the last immediate byte arrives. A memory result needs a byte-serial read-modify-write that takes nine cycles. An encoding outside the supported set stops the executor until reset. A host side port lets the surrounding logic load and inspect registers and memory while the executor is idle.

Top module: `imm_alu_exec`

## Requirements
- R1: After reset, in_ready is 1, done and illegal are 0, and all eight registers read 0.
- R2: The four bytes after the opcode (or after the addressing byte) form the immediate, least significant byte first. For example, bytes 0a 0b 0c 0d give 0x0d0c0b0a.
- R3: Opcode 0x81 is followed by an addressing byte. Bits 5:3 of that byte select the operation: 0 add, 1 OR, 4 AND, 5 subtract, 6 XOR. When bits 7:6 are 3, the destination is the register numbered by bits 2:0.
- R4: Opcodes 0x2D, 0x25, 0x0D and 0x35 have no addressing byte. They apply subtract, AND, OR and XOR respectively to register 0.
- R5: For opcode 0x81 with bits 7:6 equal to 0, the destination is the four bytes at addresses A..A+3, taken little-endian. A is the low 8 bits of the register numbered by bits 2:0. No other byte of memory changes.
- R6: Subtract stores destination minus immediate. Add and subtract wrap modulo 2^32.
- R7: done is high for exactly one cycle per executed instruction. It is seen 2 cycles after the last immediate byte is accepted for a register destination, and 10 cycles after for a memory destination.
- R8: in_ready stays low from the acceptance of the last immediate byte until done rises. in_ready is high again while done is high.
- R9: After 0x81, an operation code of 2, 3 or 7 raises illegal from the next cycle. illegal then stays set, in_ready stays 0 and no state is written, until reset.
- R10: After 0x81, bits 7:6 equal to 1 or 2, or bits 7:6 equal to 0 with bits 2:0 equal to 4 or 5, raise illegal with the same sticky behaviour as R9.
- R11: Any opcode other than 0x81, 0x2D, 0x25, 0x0D and 0x35 raises illegal with the same sticky behaviour as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Instruction byte |
| in_valid | input | 1 | in_byte is offered |
| in_ready | output | 1 | Executor accepts a byte this cycle |
| done | output | 1 | One-cycle pulse after writeback |
| illegal | output | 1 | Sticky unsupported-encoding indication |
| host_reg_we | input | 1 | Host register write (idle only) |
| host_reg_wsel | input | 3 | Host register write index |
| host_reg_wdata | input | 32 | Host register write value |
| host_reg_rsel | input | 3 | Host register read index |
| host_reg_rdata | output | 32 | Register value at host_reg_rsel (combinational) |
| host_mem_we | input | 1 | Host memory byte write (idle only) |
| host_mem_addr | input | 8 | Host memory byte address |
| host_mem_wdata | input | 8 | Host memory write byte |
| host_mem_rdata | output | 8 | Byte at host_mem_addr of the previous cycle |

## Verification
Every grouped operation is run against a register destination with operands chosen so that each operation gives a different result. This tells the operation selection apart from the register selection. The short forms use the same operands on register 0, which shows that the opcode picks the operation there and no addressing byte is consumed. Memory-destination runs use base registers with nonzero upper bits, and values whose add carries across all four bytes. These runs expose byte-order errors, carry breaks between bytes, address truncation and stray writes to neighbouring bytes. Each unsupported operation code, addressing mode and opcode is offered, with further bytes held on the input afterwards. These runs show that the executor stops and that nothing is written.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_OR  = 3'd1,
    ALU_AND = 3'd4,
    ALU_SUB = 3'd5,
    ALU_XOR = 3'd6
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_MODRM,
    ST_IMM,
    ST_REGWB,
    ST_MRD,
    ST_MWR,
    ST_HALT
  } exec_state_e;

  localparam logic [7:0] OPC_GROUP = 8'h81;
  localparam logic [7:0] OPC_SUB_A = 8'h2D;
  localparam logic [7:0] OPC_AND_A = 8'h25;
  localparam logic [7:0] OPC_OR_A  = 8'h0D;
  localparam logic [7:0] OPC_XOR_A = 8'h35;

  function automatic logic sub_code_ok(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd4) ||
           (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic addr_mode_ok(input logic [1:0] md, input logic [2:0] rm);
    return (md == 2'd3) || ((md == 2'd0) && (rm != 3'd4) && (rm != 3'd5));
  endfunction

endpackage

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/imm_regfile.sv
module imm_regfile #(
  parameter int W = 32,
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel_a,
  output logic [W-1:0]  rdata_a,
  input  logic [SW-1:0] rsel_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign rdata_a = regs[rsel_a];
  assign rdata_b = regs[rsel_b];

endmodule

// File: rtl/imm_datamem.sv
module imm_datamem #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/imm_alu_exec.sv
module imm_alu_exec
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  parameter int MEM_AW = 8,
  localparam int RSEL_W = $clog2(REG_N),
  localparam int NBYTES = DATA_W / 8,
  localparam int BI_W   = $clog2(NBYTES),
  localparam int CNT_W  = BI_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              done,
  output logic              illegal,
  input  logic              host_reg_we,
  input  logic [RSEL_W-1:0] host_reg_wsel,
  input  logic [DATA_W-1:0] host_reg_wdata,
  input  logic [RSEL_W-1:0] host_reg_rsel,
  output logic [DATA_W-1:0] host_reg_rdata,
  input  logic              host_mem_we,
  input  logic [MEM_AW-1:0] host_mem_addr,
  input  logic [7:0]        host_mem_wdata,
  output logic [7:0]        host_mem_rdata
);

  exec_state_e       state_q;
  alu_op_e           op_q;
  logic [RSEL_W-1:0] dst_q;
  logic              to_mem_q;
  logic [DATA_W-1:0] imm_q;
  logic [DATA_W-1:0] word_q;
  logic [MEM_AW-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              illegal_q;

  logic              accept;
  logic [DATA_W-1:0] rf_dst;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_y;
  logic              core_mem;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;
  logic              rf_we;
  logic [RSEL_W-1:0] rf_wsel;
  logic [DATA_W-1:0] rf_wdata;
  logic [BI_W-1:0]   byte_idx;
  logic [BI_W-1:0]   cap_idx;

  assign in_ready = (state_q == ST_OPC) || (state_q == ST_MODRM) || (state_q == ST_IMM);
  assign accept   = in_valid && in_ready;
  assign done     = done_q;
  assign illegal  = illegal_q;
  assign byte_idx = cnt_q[BI_W-1:0];
  assign cap_idx  = byte_idx - BI_W'(1);

  // register file: executor write has priority over host write
  assign rf_we    = (state_q == ST_REGWB) || host_reg_we;
  assign rf_wsel  = (state_q == ST_REGWB) ? dst_q : host_reg_wsel;
  assign rf_wdata = (state_q == ST_REGWB) ? alu_y : host_reg_wdata;

  imm_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .wsel    (rf_wsel),
    .wdata   (rf_wdata),
    .rsel_a  (dst_q),
    .rdata_a (rf_dst),
    .rsel_b  (host_reg_rsel),
    .rdata_b (host_reg_rdata)
  );

  assign alu_a = to_mem_q ? word_q : rf_dst;

  imm_alu #(.W(DATA_W)) u_alu (
    .op (op_q),
    .a  (alu_a),
    .b  (imm_q),
    .y  (alu_y)
  );

  // memory port: executor owns it during read-modify-write
  assign core_mem  = (state_q == ST_MRD) || (state_q == ST_MWR);
  assign mem_addr  = core_mem ? (base_q + MEM_AW'(byte_idx)) : host_mem_addr;
  assign mem_we    = (state_q == ST_MWR) || (!core_mem && host_mem_we);
  assign mem_wdata = (state_q == ST_MWR) ? alu_y[byte_idx*8 +: 8] : host_mem_wdata;
  assign host_mem_rdata = mem_rdata;

  imm_datamem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OPC;
      op_q      <= ALU_ADD;
      dst_q     <= '0;
      to_mem_q  <= 1'b0;
      imm_q     <= '0;
      word_q    <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_OPC: if (accept) begin
          cnt_q    <= '0;
          dst_q    <= '0;
          to_mem_q <= 1'b0;
          state_q  <= ST_IMM;
          case (in_byte)
            OPC_GROUP: state_q <= ST_MODRM;
            OPC_SUB_A: op_q <= ALU_SUB;
            OPC_AND_A: op_q <= ALU_AND;
            OPC_OR_A:  op_q <= ALU_OR;
            OPC_XOR_A: op_q <= ALU_XOR;
            default: begin
              illegal_q <= 1'b1;
              state_q   <= ST_HALT;
            end
          endcase
        end
        ST_MODRM: if (accept) begin
          if (sub_code_ok(in_byte[5:3]) && addr_mode_ok(in_byte[7:6], in_byte[2:0])) begin
            op_q     <= alu_op_e'(in_byte[5:3]);
            dst_q    <= RSEL_W'(in_byte[2:0]);
            to_mem_q <= (in_byte[7:6] == 2'd0);
            state_q  <= ST_IMM;
          end else begin
            illegal_q <= 1'b1;
            state_q   <= ST_HALT;
          end
        end
        ST_IMM: if (accept) begin
          imm_q[byte_idx*8 +: 8] <= in_byte;
          if (cnt_q == CNT_W'(NBYTES - 1)) begin
            cnt_q   <= '0;
            base_q  <= rf_dst[MEM_AW-1:0];
            state_q <= to_mem_q ? ST_MRD : ST_REGWB;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_REGWB: begin
          done_q  <= 1'b1;
          state_q <= ST_OPC;
        end
        ST_MRD: begin
          // read issued at count k returns one cycle later
          if (cnt_q != '0) word_q[cap_idx*8 +: 8] <= mem_rdata;
          if (cnt_q == CNT_W'(NBYTES)) begin
            cnt_q   <= '0;
            state_q <= ST_MWR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MWR: begin
          if (cnt_q == CNT_W'(NBYTES - 1)) begin
            cnt_q   <= '0;
            done_q  <= 1'b1;
            state_q <= ST_OPC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_OPC;
      endcase
    end
  end

endmodule

// File: rtl/imm_alu_exec_chk.sv
module imm_alu_exec_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic done,
  input logic illegal
);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !done && !illegal));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_before_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(in_ready));

  p_ready_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  p_halt_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!in_ready && !done));

endmodule

bind imm_alu_exec imm_alu_exec_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .done     (done),
  .illegal  (illegal)
);

// File: tb/imm_alu_exec_tb.sv
module imm_alu_exec_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, done, illegal;
  logic        host_reg_we = 1'b0;
  logic [2:0]  host_reg_wsel = '0;
  logic [31:0] host_reg_wdata = '0;
  logic [2:0]  host_reg_rsel = '0;
  logic [31:0] host_reg_rdata;
  logic        host_mem_we = 1'b0;
  logic [7:0]  host_mem_addr = '0;
  logic [7:0]  host_mem_wdata = '0;
  logic [7:0]  host_mem_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_reg [8];
  logic [7:0]  m_mem [256];

  always #5 clk = ~clk;

  imm_alu_exec u_dut (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .done(done), .illegal(illegal),
    .host_reg_we(host_reg_we), .host_reg_wsel(host_reg_wsel),
    .host_reg_wdata(host_reg_wdata), .host_reg_rsel(host_reg_rsel),
    .host_reg_rdata(host_reg_rdata), .host_mem_we(host_mem_we),
    .host_mem_addr(host_mem_addr), .host_mem_wdata(host_mem_wdata),
    .host_mem_rdata(host_mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input int code, input logic [31:0] a, input logic [31:0] b);
    case (code)
      0: return a + b;
      1: return a | b;
      4: return a & b;
      5: return a - b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic set_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    host_reg_we = 1'b1; host_reg_wsel = 3'(i); host_reg_wdata = v;
    @(posedge clk); #1;
    host_reg_we = 1'b0;
    m_reg[i] = v;
  endtask

  task automatic set_mem(input int a, input logic [7:0] v);
    @(negedge clk);
    host_mem_we = 1'b1; host_mem_addr = 8'(a); host_mem_wdata = v;
    @(posedge clk); #1;
    host_mem_we = 1'b0;
    m_mem[a] = v;
  endtask

  task automatic get_mem(input int a, output logic [7:0] v);
    @(negedge clk);
    host_mem_addr = 8'(a);
    @(posedge clk); #1;
    v = host_mem_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_imm(input logic [31:0] v);
    for (int k = 0; k < 4; k++) send_byte(v[k*8 +: 8]);
  endtask

  task automatic compare_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      host_reg_rsel = 3'(i); #1;
      chk(req, host_reg_rdata, m_reg[i]);
    end
  endtask

  task automatic compare_mem(input string req, input int base);
    logic [7:0] v;
    for (int k = -1; k < 5; k++) begin
      get_mem((base + k) & 255, v);
      chk(req, {24'd0, v}, {24'd0, m_mem[(base + k) & 255]});
    end
  endtask

  // R7/R8: done timing and ready-low window after last immediate byte
  task automatic wait_done(input int exp_lat, input string req);
    int n = 0;
    int early_ready = 0;
    do begin
      @(negedge clk);
      n++;
      if (!done && in_ready) early_ready++;
    end while (!done && n < 30);
    chk({req, " R7 latency"}, 32'(n), 32'(exp_lat));
    chk({req, " R8 ready low while busy"}, 32'(early_ready), 32'd0);
    chk({req, " R8 ready at done"}, {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk({req, " R7 single pulse"}, {31'd0, done}, 32'd0);
  endtask

  task automatic run_grp(input logic [7:0] modrm, input logic [31:0] imm, input string req);
    int md = modrm[7:6];
    int code = modrm[5:3];
    int rm = modrm[2:0];
    int base = m_reg[rm][7:0];
    logic [31:0] w;
    send_byte(8'h81); send_byte(modrm); send_imm(imm);
    if (md == 3) begin
      m_reg[rm] = ref_op(code, m_reg[rm], imm);
      wait_done(2, req);
      compare_regs(req);
    end else begin
      for (int k = 0; k < 4; k++) w[k*8 +: 8] = m_mem[(base + k) & 255];
      w = ref_op(code, w, imm);
      for (int k = 0; k < 4; k++) m_mem[(base + k) & 255] = w[k*8 +: 8];
      wait_done(10, req);
      compare_mem(req, base);
      compare_regs(req);
    end
  endtask

  task automatic run_short(input logic [7:0] opc, input logic [31:0] imm, input string req);
    int code = (opc == 8'h2D) ? 5 : (opc == 8'h25) ? 4 : (opc == 8'h0D) ? 1 : 6;
    send_byte(opc); send_imm(imm);
    m_reg[0] = ref_op(code, m_reg[0], imm);
    wait_done(2, req);
    compare_regs(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    @(negedge clk);
  endtask

  // offer bytes, then keep offering more while checking halt behaviour
  task automatic expect_halt(input logic [7:0] b0, input logic [7:0] b1, input bit two, input string req);
    int seen_done = 0;
    int seen_ready = 0;
    send_byte(b0);
    if (two) send_byte(b1);
    @(negedge clk);
    chk({req, " illegal raised"}, {31'd0, illegal}, 32'd1);
    in_valid = 1'b1; in_byte = 8'h01;
    repeat (8) begin
      @(negedge clk);
      if (done) seen_done++;
      if (in_ready) seen_ready++;
    end
    in_valid = 1'b0;
    chk({req, " illegal sticky"}, {31'd0, illegal}, 32'd1);
    chk({req, " no ready while halted"}, 32'(seen_ready), 32'd0);
    chk({req, " no done while halted"}, 32'(seen_done), 32'd0);
    compare_regs({req, " no writeback"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, in_ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    compare_regs("R1 registers");

    for (int a = 0; a < 256; a++) set_mem(a, 8'(a) ^ 8'h5a);

    // R2 + R3: add to register 3, byte order of immediate
    set_reg(3, 32'd1);
    run_grp(8'hC3, 32'h0d0c0b0a, "R3 add reg");
    host_reg_rsel = 3'd3; #1;
    chk("R2 little-endian immediate", host_reg_rdata, 32'h0d0c0b0b);
    // R6 subtract order
    set_reg(3, 32'd10);
    run_grp(8'hEB, 32'd1, "R6 sub reg");
    host_reg_rsel = 3'd3; #1;
    chk("R6 dest minus imm", host_reg_rdata, 32'd9);
    set_reg(3, 32'hd0c0b0a0);
    run_grp(8'hCB, 32'h0d0c0b0a, "R3 or reg");
    set_reg(3, 32'h000000ff);
    run_grp(8'hE3, 32'h0d0c0b0a, "R3 and reg");
    set_reg(7, 32'hd0c0b0a0);
    run_grp(8'hF7, 32'h0d0c0bff, "R3 xor reg7");
    set_reg(5, 32'hfffffff0);
    run_grp(8'hC5, 32'h00000020, "R6 add wrap reg5");

    // R4 short forms on register 0
    set_reg(0, 32'h0d0c0baa);
    run_short(8'h2D, 32'h0d0c0b0a, "R4 sub r0");
    set_reg(0, 32'h000000ff);
    run_short(8'h25, 32'h0d0c0b0a, "R4 and r0");
    set_reg(0, 32'hd0c0b0a0);
    run_short(8'h0D, 32'h0d0c0b0a, "R4 or r0");
    set_reg(0, 32'hddccb0a0);
    run_short(8'h35, 32'h0d0c0b0a, "R4 xor r0");
    set_reg(0, 32'd0);
    run_short(8'h2D, 32'd1, "R6 sub wrap r0");

    // R5 memory destination
    set_reg(3, 32'h00000060);
    set_mem(8'h60, 8'ha0); set_mem(8'h61, 8'hb0);
    set_mem(8'h62, 8'hc0); set_mem(8'h63, 8'hd0);
    run_grp(8'h0B, 32'h0d0c0b0a, "R5 or mem");
    run_grp(8'h2B, 32'd1, "R5 sub mem");
    run_grp(8'h33, 32'h12345678, "R5 xor mem");
    run_grp(8'h23, 32'hff00ff0f, "R5 and mem");
    set_reg(6, 32'h1234_0090);
    for (int k = 0; k < 4; k++) set_mem(8'h90 + k, 8'hff);
    run_grp(8'h06, 32'd1, "R5 add carry mem high-bits base");
    set_reg(2, 32'h000000fe);
    run_grp(8'h02, 32'h01020304, "R5 add mem address wrap");

    // R9 illegal operation codes
    set_reg(3, 32'h00000042);
    expect_halt(8'h81, 8'hD3, 1'b1, "R9 opcode 2");
    do_reset();
    set_reg(3, 32'h00000042);
    expect_halt(8'h81, 8'h1B, 1'b1, "R9 opcode 3");
    do_reset();
    expect_halt(8'h81, 8'hFB, 1'b1, "R9 opcode 7");
    do_reset();
    // R10 unsupported addressing
    expect_halt(8'h81, 8'h43, 1'b1, "R10 mod 1");
    do_reset();
    expect_halt(8'h81, 8'h83, 1'b1, "R10 mod 2");
    do_reset();
    expect_halt(8'h81, 8'h04, 1'b1, "R10 rm 4");
    do_reset();
    expect_halt(8'h81, 8'h05, 1'b1, "R10 rm 5");
    do_reset();
    // R11 unknown opcodes
    expect_halt(8'h90, 8'h00, 1'b0, "R11 opcode 90");
    do_reset();
    expect_halt(8'h05, 8'h00, 1'b0, "R11 opcode 05");
    do_reset();
    chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R1 illegal cleared", {31'd0, illegal}, 32'd0);
    set_reg(1, 32'd7);
    run_grp(8'hC1, 32'd5, "R3 add after recovery");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule